// File: doc/BRIEF.md
# Tagged Entry Packing FIFO

This block sits between a 32-bit register bus and a byte-oriented serial engine and holds two queues of 16-bit tagged entries. An entry carries a 3-bit tag in bits [10:8] and a data byte in bits [7:0]. Bits [15:11] are reserved and pass through unchanged. Toward the engine, one bus write can deposit two entries. Toward the bus, one read can collect two entries that the engine has delivered. Because each byte travels with its tag, a bus word moves at most two data bytes.

Each direction runs either as a plain FIFO or in block mode. In block mode a programmed total bounds the transfer, and a one-cycle service pulse marks every completed block and the end of the transfer. Block size and queue depth are build-time codes. The same codes are reported on a read-only size descriptor, together with the current mode selections, so that software can size its transfers.

Top module: `tagged_pack_fifo`

## Requirements
- R1: A synchronous reset empties both queues and clears every counter and service flag. After reset `eo_valid`, `in_nonempty`, `out_svc` and `in_svc` are 0, `br_data` is 0, and `bw_ready` is 1.
- R2: With `mode_unpack`=1, an accepted bus write queues `bw_data[15:0]` first and then `bw_data[31:16]`. With `mode_unpack`=0 it queues only `bw_data[15:0]`. The engine receives entries in queue order on `eo_entry`, and an entry leaves the queue when `eo_take` is high while `eo_valid` is high.
- R3: `bw_ready` is 1 exactly when the output queue has free space for the entries of one write (2 entries with unpack, 1 without). A write while `bw_ready` is 0 is ignored.
- R4: With `mode_pack`=1 and at least two entries held, `br_data` carries the earlier entry in [15:0] and the later one in [31:16], so its tag is at [26:24] and its byte at [23:16]. A read request removes both entries. With only one entry held, or with `mode_pack`=0, `br_data` is {16'h0, earliest entry} and a read request removes one entry.
- R5: `in_nonempty` is 1 exactly when the input queue holds an entry. A read request on an empty input queue returns 0 and changes nothing.
- R6: `ei_ready` is 0 while the input queue is full. An entry is accepted when `ei_valid` and `ei_ready` are both 1.
- R7: `size_desc` reports the following fields:
  - [1:0] output block code
  - [4:2] output multiplier code
  - [6:5] input block code
  - [9:7] input multiplier code
  - bit 10 `mode_wr_blk`
  - bit 12 `mode_rd_blk`
  - bit 14 `mode_unpack`
  - bit 15 `mode_pack`
  - other bits 0

  With the defaults the descriptor is 16'h00C0 plus the mode bits.
- R8: A block code c means 16·c entries, and code 0 means 16 entries. A queue holds block × (2 << multiplier) entries. With the defaults the output queue holds 32 entries (block 16) and the input queue holds 128 entries (block 32).
- R9: With `mode_wr_blk`=1, `out_svc` pulses for one cycle in the cycle after a take that completes a block of output entries or brings the taken count to `wr_total`. Once `wr_total` entries have been taken, `eo_valid` stays 0.
- R10: With `mode_rd_blk`=1, `in_svc` pulses for one cycle in the cycle after an accepted entry that completes an input block or brings the received count to `rd_total`. Once `rd_total` entries have been received, `ei_ready` stays 0.
- R11: With a block mode off, that direction never raises its service pulse and its total has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_wr_blk | input | 1 | Block mode for the output direction |
| mode_rd_blk | input | 1 | Block mode for the input direction |
| mode_unpack | input | 1 | Two entries per bus write |
| mode_pack | input | 1 | Two entries per bus read |
| wr_total | input | CNTW | Output entries in a block-mode transfer |
| rd_total | input | CNTW | Input entries in a block-mode transfer |
| bw_valid | input | 1 | Bus write strobe |
| bw_data | input | 32 | Bus write word |
| bw_ready | output | 1 | Output queue can take one write |
| eo_valid | output | 1 | Entry available to the engine |
| eo_entry | output | 16 | Head entry of the output queue |
| eo_take | input | 1 | Engine consumes the head entry |
| ei_valid | input | 1 | Engine offers an entry |
| ei_entry | input | 16 | Entry from the engine |
| ei_ready | output | 1 | Input queue accepts an entry |
| br_req | input | 1 | Bus read, pops what `br_data` shows |
| br_data | output | 32 | Packed read word |
| in_nonempty | output | 1 | Input queue holds data |
| out_svc | output | 1 | Output block service pulse |
| in_svc | output | 1 | Input block service pulse |
| size_desc | output | 16 | Size and mode descriptor |

## Verification
A wrong fill count in either queue shows at the edge within one cycle. `bw_ready` or `ei_ready` would drop one entry early or late, or `br_data` would switch between packed and single-entry form at the wrong depth. A read or write pointer that slips shows on the next entry the engine or the bus sees, as an entry out of order or a duplicated entry. A block counter that is off by one moves an `out_svc` or `in_svc` pulse by one cycle relative to the completing transfer. It also shuts `eo_valid` or `ei_ready` one entry early or late, which an every-cycle comparison catches at that boundary.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int ENTRY_W = 16;
  localparam int WORD_W  = 32;

  // entries in one block for a 2-bit block code; code 0 stands for 16
  function automatic int blk_entries(input int code);
    return (code == 0) ? 16 : code * 16;
  endfunction

  // queue depth from block code and multiplier code
  function automatic int fifo_depth(input int blk_code, input int mult_code);
    return blk_entries(blk_code) * (2 << mult_code);
  endfunction

  // low ten bits of the descriptor
  function automatic logic [9:0] size_fields(input int ob, input int om,
                                             input int ib, input int im);
    return {3'(im), 2'(ib), 3'(om), 2'(ob)};
  endfunction
endpackage

// File: rtl/tpf_entry_fifo.sv
module tpf_entry_fifo #(
  parameter int DEPTH = 32,
  parameter int EW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push_n,
  input  logic [EW-1:0] push_lo,
  input  logic [EW-1:0] push_hi,
  input  logic [1:0]    pop_n,
  output logic [EW-1:0] head_lo,
  output logic [EW-1:0] head_hi,
  output logic [CW-1:0] fill
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW-1:0] wp_1, rp_1;

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  assign wp_1    = wrap_add(wp, 1);
  assign rp_1    = wrap_add(rp, 1);
  assign head_lo = mem[rp];
  assign head_hi = mem[rp_1];

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp] <= push_lo;
    if (push_n == 2'd2) mem[wp_1] <= push_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      wp   <= wrap_add(wp, int'(push_n));
      rp   <= wrap_add(rp, int'(pop_n));
      fill <= fill + CW'(push_n) - CW'(pop_n);
    end
  end

  // R3: the controller never pushes beyond the free space
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    int'(push_n) <= DEPTH - int'(fill));

  // R5: the controller never pops more than is held
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    int'(pop_n) <= int'(fill));
endmodule

// File: rtl/tpf_block_tracker.sv
module tpf_block_tracker #(
  parameter int BLK  = 16,
  parameter int CNTW = 16,
  localparam int SW  = $clog2(BLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blk_mode,
  input  logic            ev,
  input  logic [CNTW-1:0] total,
  output logic            svc,
  output logic            done
);
  logic [CNTW-1:0] cnt;
  logic [SW-1:0]   sub;
  logic            blk_end, xfer_end;

  assign blk_end  = (sub == SW'(BLK - 1));
  assign xfer_end = ((cnt + CNTW'(1)) == total);
  assign done     = (cnt == total);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sub <= '0;
      svc <= 1'b0;
    end else begin
      svc <= blk_mode && ev && (blk_end || xfer_end);
      if (ev) begin
        cnt <= cnt + CNTW'(1);
        sub <= blk_end ? '0 : sub + SW'(1);
      end
    end
  end

  // R9 / R10: a service pulse always follows a counted event
  assert_svc_after_event_R9: assert property (@(posedge clk) disable iff (rst)
    svc |-> $past(ev));

  // R10: in block mode the count never passes the programmed total
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    blk_mode |-> cnt <= total);

  // R11: no pulse while block mode is off
  assert_fifo_mode_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !blk_mode |=> !svc);
endmodule

// File: rtl/tagged_pack_fifo.sv
module tagged_pack_fifo
  import tpf_pkg::*;
#(
  parameter int OUT_BLK_CODE  = 0,
  parameter int OUT_MULT_CODE = 0,
  parameter int IN_BLK_CODE   = 2,
  parameter int IN_MULT_CODE  = 1,
  parameter int CNTW          = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_wr_blk,
  input  logic            mode_rd_blk,
  input  logic            mode_unpack,
  input  logic            mode_pack,
  input  logic [CNTW-1:0] wr_total,
  input  logic [CNTW-1:0] rd_total,
  input  logic            bw_valid,
  input  logic [31:0]     bw_data,
  output logic            bw_ready,
  output logic            eo_valid,
  output logic [15:0]     eo_entry,
  input  logic            eo_take,
  input  logic            ei_valid,
  input  logic [15:0]     ei_entry,
  output logic            ei_ready,
  input  logic            br_req,
  output logic [31:0]     br_data,
  output logic            in_nonempty,
  output logic            out_svc,
  output logic            in_svc,
  output logic [15:0]     size_desc
);
  localparam int ODEPTH = fifo_depth(OUT_BLK_CODE, OUT_MULT_CODE);
  localparam int IDEPTH = fifo_depth(IN_BLK_CODE, IN_MULT_CODE);
  localparam int OBLK   = blk_entries(OUT_BLK_CODE);
  localparam int IBLK   = blk_entries(IN_BLK_CODE);
  localparam int OCW    = $clog2(ODEPTH + 1);
  localparam int ICW    = $clog2(IDEPTH + 1);
  localparam int HW     = WORD_W / 2;

  // output direction
  logic [1:0]     o_push_n, o_pop_n;
  logic [15:0]    o_head_lo, o_head_hi;
  logic [OCW-1:0] o_fill;
  logic           o_take_ev, o_done;

  // input direction
  logic [1:0]     i_push_n, i_pop_n;
  logic [15:0]    i_head_lo, i_head_hi;
  logic [ICW-1:0] i_fill;
  logic           i_push_ev, i_done, i_two;

  always_comb begin
    bw_ready  = (int'(o_fill) + (mode_unpack ? 2 : 1)) <= ODEPTH;
    o_push_n  = (bw_valid && bw_ready) ? (mode_unpack ? 2'd2 : 2'd1) : 2'd0;
    eo_valid  = (o_fill != '0) && !(mode_wr_blk && o_done);
    o_take_ev = eo_take && eo_valid;
    o_pop_n   = {1'b0, o_take_ev};
  end
  assign eo_entry = o_head_lo;

  tpf_entry_fifo #(.DEPTH(ODEPTH), .EW(ENTRY_W)) u_out_q (
    .clk(clk), .rst(rst),
    .push_n(o_push_n), .push_lo(bw_data[HW-1:0]), .push_hi(bw_data[WORD_W-1:HW]),
    .pop_n(o_pop_n), .head_lo(o_head_lo), .head_hi(o_head_hi), .fill(o_fill)
  );

  tpf_block_tracker #(.BLK(OBLK), .CNTW(CNTW)) u_out_trk (
    .clk(clk), .rst(rst), .blk_mode(mode_wr_blk), .ev(o_take_ev),
    .total(wr_total), .svc(out_svc), .done(o_done)
  );

  always_comb begin
    ei_ready  = (int'(i_fill) < IDEPTH) && !(mode_rd_blk && i_done);
    i_push_ev = ei_valid && ei_ready;
    i_push_n  = {1'b0, i_push_ev};
    i_two     = mode_pack && (int'(i_fill) >= 2);
    if (i_fill == '0)  br_data = '0;
    else if (i_two)    br_data = {i_head_hi, i_head_lo};
    else               br_data = {16'h0000, i_head_lo};
    if (!br_req || i_fill == '0) i_pop_n = 2'd0;
    else                         i_pop_n = i_two ? 2'd2 : 2'd1;
  end
  assign in_nonempty = (i_fill != '0);

  tpf_entry_fifo #(.DEPTH(IDEPTH), .EW(ENTRY_W)) u_in_q (
    .clk(clk), .rst(rst),
    .push_n(i_push_n), .push_lo(ei_entry), .push_hi(ei_entry),
    .pop_n(i_pop_n), .head_lo(i_head_lo), .head_hi(i_head_hi), .fill(i_fill)
  );

  tpf_block_tracker #(.BLK(IBLK), .CNTW(CNTW)) u_in_trk (
    .clk(clk), .rst(rst), .blk_mode(mode_rd_blk), .ev(i_push_ev),
    .total(rd_total), .svc(in_svc), .done(i_done)
  );

  assign size_desc = {mode_pack, mode_unpack, 1'b0, mode_rd_blk, 1'b0, mode_wr_blk,
                      size_fields(OUT_BLK_CODE, OUT_MULT_CODE, IN_BLK_CODE, IN_MULT_CODE)};

  // R9: nothing leaves the output queue once a block-mode transfer is complete
  assert_out_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_blk && o_done) |-> !o_take_ev);

  // R10: nothing enters the input queue once a block-mode transfer is complete
  assert_in_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_rd_blk && i_done) |-> !i_push_ev);
endmodule

// File: tb/tagged_pack_fifo_tb.sv
module tagged_pack_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ODEPTH = 32;
  localparam int IDEPTH = 128;
  localparam int OBLK   = 16;
  localparam int IBLK   = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr_blk = 0, mode_rd_blk = 0, mode_unpack = 0, mode_pack = 0;
  logic [15:0] wr_total = 0, rd_total = 0;
  logic        bw_valid = 0;
  logic [31:0] bw_data = 0;
  logic        bw_ready;
  logic        eo_valid;
  logic [15:0] eo_entry;
  logic        eo_take = 0;
  logic        ei_valid = 0;
  logic [15:0] ei_entry = 0;
  logic        ei_ready;
  logic        br_req = 0;
  logic [31:0] br_data;
  logic        in_nonempty, out_svc, in_svc;
  logic [15:0] size_desc;

  tagged_pack_fifo u_dut (
    .clk(clk), .rst(rst), .mode_wr_blk(mode_wr_blk), .mode_rd_blk(mode_rd_blk),
    .mode_unpack(mode_unpack), .mode_pack(mode_pack), .wr_total(wr_total),
    .rd_total(rd_total), .bw_valid(bw_valid), .bw_data(bw_data), .bw_ready(bw_ready),
    .eo_valid(eo_valid), .eo_entry(eo_entry), .eo_take(eo_take), .ei_valid(ei_valid),
    .ei_entry(ei_entry), .ei_ready(ei_ready), .br_req(br_req), .br_data(br_data),
    .in_nonempty(in_nonempty), .out_svc(out_svc), .in_svc(in_svc), .size_desc(size_desc)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] lf = 32'h1ACE_B00C;
  logic [15:0] oq[$];
  logic [15:0] iq[$];
  int taken, rcvd;
  bit osvc_exp, isvc_exp;

  function automatic int rnd100();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return int'(lf[15:0]) % 100;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_bw_ready();
    return (ODEPTH - oq.size()) >= (mode_unpack ? 2 : 1);
  endfunction
  function automatic bit m_eo_valid();
    return oq.size() > 0 && !(mode_wr_blk && taken == int'(wr_total));
  endfunction
  function automatic bit m_ei_ready();
    return iq.size() < IDEPTH && !(mode_rd_blk && rcvd == int'(rd_total));
  endfunction
  function automatic logic [31:0] m_br_data();
    if (iq.size() == 0) return 32'h0;
    if (mode_pack && iq.size() >= 2) return {iq[1], iq[0]};
    return {16'h0, iq[0]};
  endfunction

  task automatic compare_all();
    chk("R3", "bw_ready", bw_ready, m_bw_ready());
    chk(mode_wr_blk ? "R9" : "R2", "eo_valid", eo_valid, m_eo_valid());
    if (m_eo_valid()) chk("R2", "eo_entry", eo_entry, oq[0]);
    chk(mode_rd_blk ? "R10" : "R6", "ei_ready", ei_ready, m_ei_ready());
    chk("R4", "br_data", br_data, m_br_data());
    chk("R5", "in_nonempty", in_nonempty, iq.size() > 0);
    chk(mode_wr_blk ? "R9" : "R11", "out_svc", out_svc, osvc_exp);
    chk(mode_rd_blk ? "R10" : "R11", "in_svc", in_svc, isvc_exp);
  endtask

  // inputs are already set; advance one clock and update the model
  task automatic tick();
    bit bwr, eov, eir;
    int npop;
    bwr = m_bw_ready();
    eov = m_eo_valid();
    eir = m_ei_ready();
    npop = 0;
    if (br_req && iq.size() > 0) npop = (mode_pack && iq.size() >= 2) ? 2 : 1;
    @(posedge clk);
    osvc_exp = 0;
    isvc_exp = 0;
    if (eo_take && eov) begin
      void'(oq.pop_front());
      taken++;
      osvc_exp = mode_wr_blk && ((taken % OBLK) == 0 || taken == int'(wr_total));
    end
    if (bw_valid && bwr) begin
      oq.push_back(bw_data[15:0]);
      if (mode_unpack) oq.push_back(bw_data[31:16]);
    end
    for (int k = 0; k < npop; k++) void'(iq.pop_front());
    if (ei_valid && eir) begin
      iq.push_back(ei_entry);
      rcvd++;
      isvc_exp = mode_rd_blk && ((rcvd % IBLK) == 0 || rcvd == int'(rd_total));
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input bit wb, input bit rb, input bit un, input bit pk,
                          input int wt, input int rt);
    @(negedge clk);
    rst = 1;
    bw_valid = 0; eo_take = 0; ei_valid = 0; br_req = 0;
    mode_wr_blk = wb; mode_rd_blk = rb; mode_unpack = un; mode_pack = pk;
    wr_total = 16'(wt); rd_total = 16'(rt);
    repeat (2) @(negedge clk);
    rst = 0;
    oq.delete(); iq.delete();
    taken = 0; rcvd = 0; osvc_exp = 0; isvc_exp = 0;
    chk("R1", "eo_valid after reset", eo_valid, 1'b0);
    chk("R1", "in_nonempty after reset", in_nonempty, 1'b0);
    chk("R1", "br_data after reset", br_data, 32'h0);
    chk("R1", "bw_ready after reset", bw_ready, 1'b1);
    chk("R1", "svc after reset", {out_svc, in_svc}, 2'b00);
    chk("R7", "size_desc", size_desc,
        {pk, un, 1'b0, rb, 1'b0, wb, 10'h0C0});
    compare_all();
  endtask

  task automatic run(input int n, input int p_bw, input int p_take,
                     input int p_ei, input int p_req);
    for (int c = 0; c < n; c++) begin
      bw_valid = rnd100() < p_bw;
      bw_data  = lf ^ 32'h5A3C_96E1;
      eo_take  = rnd100() < p_take;
      ei_valid = rnd100() < p_ei;
      ei_entry = lf[31:16];
      br_req   = rnd100() < p_req;
      tick();
    end
    bw_valid = 0; eo_take = 0; ei_valid = 0; br_req = 0;
  endtask

  initial begin
    // packed traffic in plain FIFO mode
    do_reset(0, 0, 1, 1, 0, 0);
    run(400, 50, 50, 50, 40);
    // fill both queues to their depth (R8)
    run(40, 100, 0, 100, 0);
    chk("R8", "output queue full at depth", bw_ready, 1'b0);
    chk("R8", "output entries held", oq.size(), ODEPTH);
    run(100, 0, 0, 100, 0);
    chk("R6", "input queue full", ei_ready, 1'b0);
    chk("R8", "input entries held", iq.size(), IDEPTH);
    run(200, 0, 100, 0, 100);
    // empty read leaves state untouched (R5)
    br_req = 1;
    tick();
    br_req = 0;
    chk("R5", "empty read data", br_data, 32'h0);
    chk("R5", "empty read nonempty", in_nonempty, 1'b0);
    // single-entry words
    do_reset(0, 0, 0, 0, 0, 0);
    run(400, 60, 40, 60, 50);
    run(40, 100, 0, 0, 0);
    chk("R3", "unpack off depth", bw_ready, 1'b0);
    // block mode both directions
    do_reset(1, 1, 1, 1, 40, 70);
    run(600, 40, 60, 50, 50);
    chk("R9", "output transfer completed", taken, 40);
    chk("R10", "input transfer completed", rcvd, 70);
    // block mode with totals on block boundaries
    do_reset(1, 1, 0, 1, 32, 64);
    run(500, 50, 70, 60, 60);
    // FIFO mode ignores small totals (R11)
    do_reset(0, 0, 1, 0, 3, 3);
    run(300, 50, 60, 60, 40);
    chk("R11", "taken beyond total", taken > 3, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule